// File: doc/BRIEF.md
# Synthesizer Programming Slave

This block is a two-wire serial slave that loads tuning and control words into a frequency synthesizer and reports synthesizer status back to the bus master. It runs on a fast system clock and oversamples the serial clock and data lines through synchronizers. It pulls the data line low only through an open-drain enable output and never stretches the clock.

In a write transfer, every data byte after the address belongs to a self-identifying pair. The top bit of a pair's first byte chooses whether the pair carries the 15-bit divider word or the 16-bit control word. Pairs may follow one another without a new address until STOP. The divider word only changes once both of its bytes are in, or at STOP. In a read transfer, the slave returns a status byte holding a power-on flag and a phase-lock flag. It keeps sending status bytes for as long as the master acknowledges them.

Top module: `synprog_i2c_slave`

## Requirements
- R1: The slave drives SDA low in the ninth clock of the address byte only when address bits 7:1 equal SLAVE_ADDR (default 7'h61, so 0xC2 writes and 0xC3 reads). On a mismatch it leaves SDA released for the rest of that transfer, and the data sent in it changes no output.
- R2: In a write transfer to this slave, every complete data byte is acknowledged by SDA low in its ninth clock.
- R3: In a write transfer, a byte that opens a pair selects the frequency pair when its bit 7 (sent first) is 0 and the control pair when it is 1. The next byte is always taken as that pair's second byte, whatever its bit 7.
- R4: freq_word becomes {first byte bits 6:0, second byte bits 7:0} when the second byte of a frequency pair is accepted, with freq_upd high for exactly one cycle. The first byte alone never changes freq_word.
- R5: ctrl_word becomes {first byte, second byte} when the second byte of a control pair is accepted, with ctrl_upd high for exactly one cycle. The charge pump setting is ctrl_word bits 1:0.
- R6: Several pairs, of either kind and in any order, may follow one address byte. Each one is applied as it completes.
- R7: A STOP that follows only the first byte of a frequency pair commits {that byte's bits 6:0, previous freq_word bits 7:0} with one freq_upd pulse. A STOP that follows only the first byte of a control pair leaves ctrl_word unchanged.
- R8: A STOP or START arriving partway through a data byte discards that byte. freq_word and ctrl_word keep their previous values and no update pulse occurs.
- R9: In a read transfer, each status byte is sent MSB first as {power-on flag, lock_in, 6'b000000}.
- R10: A master acknowledge after a status byte starts another status byte. A missing acknowledge makes the slave release SDA and send nothing more until the next START.
- R11: The power-on flag is 1 after reset and is set whenever por_event is high. It clears at a STOP that ends a read transfer, and a write transfer leaves it unchanged.
- R12: After reset, freq_word is 0 and ctrl_word is 16'hB000. Its bits 13 and 12 (the reference/comparison output enable and select) are 1, which selects the comparison frequency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| por_event | input | 1 | Power-on or low-supply event; sets the power-on flag |
| lock_in | input | 1 | Phase-lock indication from the synthesizer |
| freq_word | output | FREQ_W (15) | Divider word |
| freq_upd | output | 1 | One-cycle strobe when freq_word is loaded |
| ctrl_word | output | 16 | Control word (first control byte in bits 15:8) |
| ctrl_upd | output | 1 | One-cycle strobe when ctrl_word is loaded |

## Verification
The bench builds the block with its defaults: SLAVE_ADDR 7'h61, two synchronizer stages and a 15-bit divider word. At this size, a walking-one sweep drives every divider bit and the bench derives each expected word arithmetically from the two bytes sent. A second sweep covers many control words, including every charge-pump code. With only two synchronizer stages, each slave response lands a few system cycles after the serial clock edge. The bench can therefore place every START, STOP and truncated byte inside a single serial bit time, and check that a partial byte really is discarded.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WDAT,
      ST_WACK,
      ST_RDAT,
      ST_RACK,
      ST_SKIP
   } bus_state_t;

   localparam int BYTE_W  = 8;
   localparam int CTRL_W  = 16;
endpackage

// File: rtl/synprog_line_sync.sv
module synprog_line_sync #(
   parameter int STAGES   = 2,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_LVL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/synprog_status.sv
module synprog_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_event,
   input  logic       lock_in,
   input  logic       clr_req,
   output logic       por_flag,
   output logic [7:0] status_byte
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         por_flag <= 1'b1;
      else if (por_event) por_flag <= 1'b1;
      else if (clr_req)   por_flag <= 1'b0;
   end

   assign status_byte = {por_flag, lock_in, 6'b000000};
endmodule

// File: rtl/synprog_pair_dec.sv
module synprog_pair_dec #(
   parameter int          FREQ_W   = 15,
   parameter int          CTRL_W   = 16,
   parameter logic [15:0] CTRL_RST = 16'hB000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [7:0]        byte_in,
   input  logic              xfer_start,
   input  logic              xfer_stop,
   output logic [FREQ_W-1:0] freq_word,
   output logic              freq_upd,
   output logic [CTRL_W-1:0] ctrl_word,
   output logic              ctrl_upd
);
   localparam int HI_W = FREQ_W - 8;

   logic            second_due;
   logic            is_ctrl;
   logic [7:0]      first_q;
   logic [HI_W-1:0] freq_hi_q;
   logic            freq_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second_due <= 1'b0;
         is_ctrl    <= 1'b0;
         first_q    <= '0;
         freq_hi_q  <= '0;
         freq_pend  <= 1'b0;
         freq_word  <= '0;
         freq_upd   <= 1'b0;
         ctrl_word  <= CTRL_RST[CTRL_W-1:0];
         ctrl_upd   <= 1'b0;
      end else begin
         freq_upd <= 1'b0;
         ctrl_upd <= 1'b0;
         if (xfer_stop) begin
            second_due <= 1'b0;
            if (freq_pend) begin
               freq_word <= {freq_hi_q, freq_word[7:0]};
               freq_upd  <= 1'b1;
               freq_pend <= 1'b0;
            end
         end else if (xfer_start) begin
            second_due <= 1'b0;
         end else if (byte_vld) begin
            if (!second_due) begin
               second_due <= 1'b1;
               is_ctrl    <= byte_in[7];
               first_q    <= byte_in;
               if (!byte_in[7]) begin
                  freq_hi_q <= byte_in[HI_W-1:0];
                  freq_pend <= 1'b1;
               end
            end else begin
               second_due <= 1'b0;
               if (is_ctrl) begin
                  ctrl_word <= {first_q, byte_in};
                  ctrl_upd  <= 1'b1;
               end else begin
                  freq_word <= {freq_hi_q, byte_in};
                  freq_upd  <= 1'b1;
                  freq_pend <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/synprog_i2c_slave.sv
module synprog_i2c_slave
   import synprog_pkg::*;
#(
   parameter logic [6:0]  SLAVE_ADDR  = 7'h61,
   parameter int          SYNC_STAGES = 2,
   parameter int          FREQ_W      = 15,
   parameter logic [15:0] CTRL_RST    = 16'hB000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic              por_event,
   input  logic              lock_in,
   output logic [FREQ_W-1:0] freq_word,
   output logic              freq_upd,
   output logic [15:0]       ctrl_word,
   output logic              ctrl_upd
);
   localparam int NLINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FREQ_W < 9 || FREQ_W > 15) begin : g_bad_freq
      $error("FREQ_W must lie between 9 and 15");
   end
   if (CTRL_RST[15] != 1'b1) begin : g_bad_ctrl
      $error("CTRL_RST bit 15 must be 1, as a control pair opens with bit 7 set");
   end

   logic [NLINES-1:0] raw_lines, sync_lines;
   assign raw_lines = {scl_in, sda_in};

   for (genvar g = 0; g < NLINES; g++) begin : g_sync
      synprog_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_lines[g]),
         .dout (sync_lines[g])
      );
   end

   logic scl_s, sda_s, scl_d, sda_d;
   assign scl_s = sync_lines[1];
   assign sda_s = sync_lines[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   logic start_det, stop_det, scl_rise, scl_fall;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;

   bus_state_t state;
   logic [3:0] bit_cnt;
   logic [7:0] shreg;
   logic       rd_xfer;
   logic       mst_ack;
   logic       byte_vld;
   logic       por_flag;
   logic [7:0] status_byte;

   synprog_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .por_event  (por_event),
      .lock_in    (lock_in),
      .clr_req    (stop_det & rd_xfer),
      .por_flag   (por_flag),
      .status_byte(status_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         rd_xfer  <= 1'b0;
         mst_ack  <= 1'b0;
         byte_vld <= 1'b0;
         sda_oe   <= 1'b0;
      end else begin
         byte_vld <= 1'b0;
         if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            rd_xfer <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state   <= ST_IDLE;
            rd_xfer <= 1'b0;
            sda_oe  <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_WDAT: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     if (state == ST_WDAT) begin
                        byte_vld <= 1'b1;
                        sda_oe   <= 1'b1;
                        state    <= ST_WACK;
                     end else if (shreg[7:1] == SLAVE_ADDR) begin
                        rd_xfer <= shreg[0];
                        sda_oe  <= 1'b1;
                        state   <= ST_AACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rd_xfer) begin
                        shreg  <= status_byte;
                        sda_oe <= ~status_byte[7];
                        state  <= ST_RDAT;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_WDAT;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     bit_cnt <= '0;
                     state   <= ST_WDAT;
                  end
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mst_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mst_ack) begin
                        bit_cnt <= '0;
                        shreg   <= status_byte;
                        sda_oe  <= ~status_byte[7];
                        state   <= ST_RDAT;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   synprog_pair_dec #(
      .FREQ_W  (FREQ_W),
      .CTRL_W  (CTRL_W),
      .CTRL_RST(CTRL_RST)
   ) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .byte_vld  (byte_vld),
      .byte_in   (shreg),
      .xfer_start(start_det),
      .xfer_stop (stop_det),
      .freq_word (freq_word),
      .freq_upd  (freq_upd),
      .ctrl_word (ctrl_word),
      .ctrl_upd  (ctrl_upd)
   );
endmodule

// File: rtl/synprog_chk.sv
module synprog_chk
   import synprog_pkg::*;
#(
   parameter int FREQ_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FREQ_W-1:0] freq_word,
   input logic              freq_upd,
   input logic [15:0]       ctrl_word,
   input logic              ctrl_upd,
   input logic              por_event,
   input logic              por_flag,
   input logic              sda_oe,
   input bus_state_t        state
);
   // R4
   freq_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_upd |=> !freq_upd);

   // R4
   freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_upd |-> $stable(freq_word));

   // R5
   ctrl_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_upd |=> !ctrl_upd);

   // R5
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_upd |-> $stable(ctrl_word));

   // R6
   one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(freq_upd && ctrl_upd));

   // R11
   por_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_event |=> por_flag);

   // R11
   por_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!por_event && !por_flag) |=> !por_flag);

   // R10
   skip_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);
endmodule

bind synprog_i2c_slave synprog_chk #(.FREQ_W(FREQ_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .freq_word(freq_word),
   .freq_upd (freq_upd),
   .ctrl_word(ctrl_word),
   .ctrl_upd (ctrl_upd),
   .por_event(por_event),
   .por_flag (por_flag),
   .sda_oe   (sda_oe),
   .state    (state)
);

// File: tb/sim_synprog_i2c_slave.sv
`timescale 1ns/1ps
module sim_synprog_i2c_slave;
   localparam int Q = 10;
   localparam logic [7:0] WADDR = 8'hC2;
   localparam logic [7:0] RADDR = 8'hC3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic por_event = 1'b0;
   logic lock_in = 1'b0;
   logic sda_oe, freq_upd, ctrl_upd;
   logic [14:0] freq_word;
   logic [15:0] ctrl_word;
   logic sda_line;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   synprog_i2c_slave u0 (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_oe(sda_oe), .por_event(por_event), .lock_in(lock_in),
      .freq_word(freq_word), .freq_upd(freq_upd),
      .ctrl_word(ctrl_word), .ctrl_upd(ctrl_upd)
   );

   int total = 0;
   int bad = 0;
   int fu_cnt = 0;
   int cu_cnt = 0;
   bit done = 1'b0;

   always @(negedge clk) begin
      if (freq_upd) fu_cnt++;
      if (ctrl_upd) cu_cnt++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tq(Q);
      scl_m = 1'b1; tq(Q);
      sda_m = 1'b0; tq(Q);
      scl_m = 1'b0; tq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tq(Q);
      scl_m = 1'b1; tq(Q);
      sda_m = 1'b1; tq(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; tq(Q);
         scl_m = 1'b1; tq(2*Q);
         scl_m = 1'b0; tq(Q);
      end
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack_lvl);
      send_bits(b, 8);
      sda_m = 1'b1; tq(Q);
      scl_m = 1'b1; tq(Q);
      ack_lvl = sda_line; tq(Q);
      scl_m = 1'b0; tq(Q);
   endtask

   task automatic rd_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tq(Q);
         scl_m = 1'b1; tq(Q);
         b[i] = sda_line; tq(Q);
         scl_m = 1'b0; tq(Q);
      end
      sda_m = give_ack ? 1'b0 : 1'b1; tq(Q);
      scl_m = 1'b1; tq(2*Q);
      scl_m = 1'b0; tq(Q);
      sda_m = 1'b1;
   endtask

   task automatic read_status(input string req, input logic [7:0] exp);
      logic a;
      logic [7:0] b;
      bus_start();
      wr_byte(RADDR, a);
      chk("R1 read address ack", {31'd0, a}, 32'd0);
      rd_byte(1'b0, b);
      chk(req, {24'd0, b}, {24'd0, exp});
      bus_stop();
   endtask

   task automatic wr_pair(input logic [7:0] b1, input logic [7:0] b2);
      logic a;
      wr_byte(b1, a);
      chk("R2 first byte ack", {31'd0, a}, 32'd0);
      wr_byte(b2, a);
      chk("R2 second byte ack", {31'd0, a}, 32'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] b;
      logic [14:0] fexp, fval;
      logic [15:0] cexp, cval;
      int fu0, cu0;

      tq(5);
      rst_n = 1'b1;
      tq(5);
      // R12 reset state
      chk("R12 freq reset", {17'd0, freq_word}, 32'd0);
      chk("R12 ctrl reset", {16'd0, ctrl_word}, 32'h0000B000);
      chk("R12 ref/comp bits", {30'd0, ctrl_word[13:12]}, 32'd3);
      chk("R12 sda released", {31'd0, sda_oe}, 32'd0);

      // R9 / R11: power-on flag after reset, lock high
      lock_in = 1'b1;
      read_status("R9 status por+lock", 8'hC0);
      lock_in = 1'b0;
      read_status("R11 por cleared by read stop", 8'h00);

      // R10: acknowledged reads continue, nack releases
      lock_in = 1'b1;
      bus_start();
      wr_byte(RADDR, a);
      chk("R1 read address ack", {31'd0, a}, 32'd0);
      rd_byte(1'b1, b);
      chk("R10 first status", {24'd0, b}, 32'h40);
      rd_byte(1'b1, b);
      chk("R10 second status after ack", {24'd0, b}, 32'h40);
      rd_byte(1'b0, b);
      chk("R10 third status", {24'd0, b}, 32'h40);
      rd_byte(1'b0, b);
      chk("R10 released after nack", {24'd0, b}, 32'hFF);
      bus_stop();

      // R3 R4: walking-one frequency sweep
      fexp = '0;
      for (int k = 0; k < 15; k++) begin
         fval = 15'((32'd1 << k) ^ ((k * 32'h2AB5) & 32'h7FF0));
         fu0 = fu_cnt;
         bus_start();
         wr_byte(WADDR, a);
         chk("R1 write address ack", {31'd0, a}, 32'd0);
         wr_byte({1'b0, fval[14:8]}, a);
         chk("R2 byte2 ack", {31'd0, a}, 32'd0);
         chk("R4 no change after first byte", {17'd0, freq_word}, {17'd0, fexp});
         wr_byte(fval[7:0] | 8'h80 & fval[7:0], a);
         chk("R2 byte3 ack", {31'd0, a}, 32'd0);
         fexp = fval;
         chk("R4 freq word", {17'd0, freq_word}, {17'd0, fexp});
         bus_stop();
         chk("R4 one strobe per pair", fu_cnt - fu0, 32'd1);
      end

      // R5 R3: control sweep, pump codes
      for (int k = 0; k < 8; k++) begin
         cval = 16'h8000 | 16'((k * 32'h1357) ^ (k << 1)) | 16'(k & 3);
         cu0 = cu_cnt;
         bus_start();
         wr_byte(WADDR, a);
         wr_pair(cval[15:8], cval[7:0]);
         cexp = cval;
         chk("R5 ctrl word", {16'd0, ctrl_word}, {16'd0, cexp});
         chk("R5 pump bits", {30'd0, ctrl_word[1:0]}, {30'd0, cval[1:0]});
         chk("R3 freq untouched by ctrl pair", {17'd0, freq_word}, {17'd0, fexp});
         bus_stop();
         chk("R5 one strobe", cu_cnt - cu0, 32'd1);
      end

      // R6 R3: several pairs in one transfer; second byte with bit7 set
      bus_start();
      wr_byte(WADDR, a);
      wr_pair(8'hA5, 8'h03);
      wr_pair(8'h12, 8'hF0);
      wr_pair(8'hC1, 8'h7E);
      bus_stop();
      fexp = 15'h12F0;
      cexp = 16'hC17E;
      chk("R6 freq after chain", {17'd0, freq_word}, {17'd0, fexp});
      chk("R6 ctrl after chain", {16'd0, ctrl_word}, {16'd0, cexp});

      // R7: stop after frequency first byte
      fu0 = fu_cnt;
      bus_start();
      wr_byte(WADDR, a);
      wr_byte(8'h35, a);
      chk("R7 first byte ack", {31'd0, a}, 32'd0);
      bus_stop();
      fexp = {7'h35, fexp[7:0]};
      chk("R7 commit at stop", {17'd0, freq_word}, {17'd0, fexp});
      chk("R7 one strobe at stop", fu_cnt - fu0, 32'd1);

      // R7: stop after control first byte
      cu0 = cu_cnt;
      bus_start();
      wr_byte(WADDR, a);
      wr_byte(8'hFF, a);
      bus_stop();
      chk("R7 ctrl unchanged", {16'd0, ctrl_word}, {16'd0, cexp});
      chk("R7 no ctrl strobe", cu_cnt - cu0, 32'd0);

      // R8: partial byte then stop
      fu0 = fu_cnt;
      bus_start();
      wr_byte(WADDR, a);
      wr_pair(8'h2A, 8'h55);
      fexp = 15'h2A55;
      send_bits(8'h00, 4);
      bus_stop();
      chk("R8 freq kept after partial", {17'd0, freq_word}, {17'd0, fexp});
      chk("R8 strobes", fu_cnt - fu0, 32'd1);

      // R8: partial second control byte then start
      cu0 = cu_cnt;
      bus_start();
      wr_byte(WADDR, a);
      wr_byte(8'h9C, a);
      send_bits(8'h11, 5);
      bus_start();
      bus_stop();
      chk("R8 ctrl kept after partial", {16'd0, ctrl_word}, {16'd0, cexp});
      chk("R8 no ctrl strobe", cu_cnt - cu0, 32'd0);

      // R1: wrong address
      fu0 = fu_cnt;
      bus_start();
      wr_byte(8'hA0, a);
      chk("R1 no ack on mismatch", {31'd0, a}, 32'd1);
      wr_byte(8'h05, a);
      chk("R1 no data ack on mismatch", {31'd0, a}, 32'd1);
      wr_byte(8'h55, a);
      bus_stop();
      chk("R1 freq unchanged", {17'd0, freq_word}, {17'd0, fexp});
      chk("R1 no strobe", fu_cnt - fu0, 32'd0);

      // R11: event sets flag, write keeps it
      lock_in = 1'b0;
      por_event = 1'b1; tq(1); por_event = 1'b0; tq(2);
      bus_start();
      wr_byte(WADDR, a);
      wr_pair(8'h01, 8'h02);
      bus_stop();
      read_status("R11 flag survives write", 8'h80);
      read_status("R11 flag cleared", 8'h00);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule